// File: doc/BRIEF.md
# Pseudo-Stop Wake-Up and Clock-Loss Controller

This block is the control state machine of a clock and reset generator that decides how the system leaves a low-power pseudo-stop state. In pseudo-stop the oscillator keeps running and the PLL is powered down. While the block is stopped, four kinds of event can end the stop:

- an external reset request;
- a watchdog reset request;
- a clock-monitor failure pulse;
- a generic wake-up interrupt.

How a clock-monitor failure is handled depends on configuration. It either starts a dedicated clock-monitor reset or moves the part into self-clock mode and wakes it through an interrupt. If that interrupt is masked, only a sticky flag is set and the part stays asleep.

The reset sequencer and the clock-quality checker are outside the block. They are driven by one-cycle start strobes and answer with done inputs. Both reset inputs act asynchronously on assertion and are released through synchronizers. On every way out of stop, the PLL select bit is cleared so that the system clock comes from the oscillator. Software must set the bit again to return to the PLL.

Top module: `stopwake_ctrl`

## Requirements
- R1: When `ext_rst_req` or `wdog_rst_req` is high, the configuration returns at once to its defaults and the block leaves stop. The defaults are monitor enable 1, self-clock enable 1, interrupt enable 0 and PLL select 0. After the synchronized release, `rseq_start` pulses for exactly one cycle. The block then enters run on `rseq_done`.
- R2: `rst_cause` reads 1 after an external reset, 2 after a watchdog reset and 3 after a clock-monitor reset. When both reset inputs are high together, the external reset wins.
- R3: `stop_req` moves the block from run to stop on the next clock edge and has no effect in any other state. `in_run`, `in_stop` and `rseq_start` are never high together.
- R4: With monitor enable (`cfg_wdata[0]`) clear, `mon_fail` has no effect.
- R5: With monitor enable set and self-clock enable (`cfg_wdata[1]`) clear, a failure in stop starts a clock-monitor reset: the configuration returns to its defaults, `rseq_start` pulses and cause 3 is recorded.
- R6: With self-clock enable and interrupt enable (`cfg_wdata[2]`) both set, a failure in stop causes the following on the next edge: `sc_flag`, `sc_irq` and `sc_active` go high, `cq_start` pulses for one cycle and the block enters run.
- R7: With self-clock enable set and interrupt enable clear, a failure in stop sets `sc_flag`. `sc_irq` stays low, no `cq_start` is issued and the block stays in stop.
- R8: `sc_flag` stays set until a `flag_clr` strobe. If interrupt enable is written to 1 in stop while the flag is pending, `sc_irq` rises and the block wakes on the following edge with a `cq_start` pulse.
- R9: `wake_irq` in stop enters run on the next edge without any reset.
- R10: PLL select (`cfg_wdata[3]`, output `pll_sel`) is cleared on every exit from stop. A software write in run sets it again.
- R11: When a failure that selects the clock-monitor reset coincides with `wake_irq`, the reset wins. A masked self-clock failure that coincides with `wake_irq` still wakes the block and leaves the flag set.
- R12: `sc_active` drops on `cq_done`.
- R13: `cfg_wr` is taken in run and in stop and ignored while the reset sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_req | input | 1 | External reset request, async, active high |
| wdog_rst_req | input | 1 | Watchdog reset request, async, active high |
| stop_req | input | 1 | Core request to enter pseudo-stop |
| mon_fail | input | 1 | Clock-monitor failure pulse |
| wake_irq | input | 1 | Enabled wake-up interrupt request |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | [0] monitor enable, [1] self-clock enable, [2] self-clock interrupt enable, [3] PLL select |
| flag_clr | input | 1 | Write-one-to-clear strobe for the self-clock flag |
| rseq_done | input | 1 | Reset sequencer finished |
| cq_done | input | 1 | Clock-quality check finished |
| rseq_start | output | 1 | One-cycle reset-sequence start strobe |
| rst_cause | output | 2 | Vector select: 1 external, 2 watchdog, 3 clock monitor |
| sc_irq | output | 1 | Self-clock interrupt request |
| sc_flag | output | 1 | Sticky self-clock flag |
| sc_active | output | 1 | Self-clock mode active |
| cq_start | output | 1 | One-cycle clock-quality-check start strobe |
| in_run | output | 1 | Block is in run |
| in_stop | output | 1 | Block is in pseudo-stop |
| pll_sel | output | 1 | PLL select bit |

## Verification
A clock-monitor failure and a wake-up interrupt can arrive in the same stop cycle. Their outcome is fixed by the configuration. The bench sweeps all eight settings of the three clock-monitor bits against the four combinations of failure and wake-up in one cycle. For each case it computes from the requirements whether the result is a reset, a self-clock wake, a plain wake or staying asleep, and checks the stop state, the strobes, the flag and the PLL select on the next cycle. A second overlap is a configuration write that unmasks the interrupt while a masked failure is pending. This is provoked directly in stop, and `sc_irq` and then the wake are checked one cycle apart.

// File: rtl/swk_pkg.sv
package swk_pkg;
   typedef enum logic [2:0] {
      ST_HOLD, ST_SEQ_GO, ST_SEQ_WAIT, ST_RUN, ST_STOP
   } swk_state_e;

   typedef struct packed {
      logic pll_sel;
      logic sc_ie;
      logic sc_en;
      logic mon_en;
   } swk_cfg_t;

   localparam int unsigned CFG_BITS = $bits(swk_cfg_t);

   localparam logic [1:0] CAUSE_NONE = 2'd0;
   localparam logic [1:0] CAUSE_EXT  = 2'd1;
   localparam logic [1:0] CAUSE_WDOG = 2'd2;
   localparam logic [1:0] CAUSE_MON  = 2'd3;
endpackage

// File: rtl/swk_rst_sync.sv
module swk_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic req,
   output logic rst_n
);
   if (STAGES < 2) begin : g_bad_stages
      $error("swk_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge req) begin
      if (req) chain <= '0;
      else     chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/swk_cfg_regs.sv
module swk_cfg_regs
   import swk_pkg::*;
#(
   parameter logic [CFG_BITS-1:0] DEFAULT = 4'b0011
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CFG_BITS-1:0] wdata,
   input  logic                restore,
   input  logic                pll_clr,
   output swk_cfg_t            cfg
);
   localparam swk_cfg_t DEF_CFG = swk_cfg_t'(DEFAULT);

   if (DEFAULT[CFG_BITS-1] != 1'b0) begin : g_bad_default
      $error("swk_cfg_regs: PLL select must default to clear");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= DEF_CFG;
      end else if (restore) begin
         cfg <= DEF_CFG;
      end else begin
         if (wr_en)   cfg         <= swk_cfg_t'(wdata);
         if (pll_clr) cfg.pll_sel <= 1'b0;
      end
   end
endmodule

// File: rtl/swk_fsm.sv
module swk_fsm
   import swk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_req,
   input  logic       mon_fail,
   input  logic       wake_irq,
   input  logic       flag_clr,
   input  logic       rseq_done,
   input  logic       cq_done,
   input  logic       mon_en,
   input  logic       sc_en,
   input  logic       sc_ie,
   output swk_state_e state,
   output logic       sc_flag,
   output logic       sc_active,
   output logic       cq_start,
   output logic       mon_rst,
   output logic       stop_exit,
   output logic       wr_allow
);
   logic stopped, mon_hit, sc_hit, sc_wake, wake;
   swk_state_e state_d;

   always_comb begin
      stopped   = (state == ST_STOP);
      mon_hit   = mon_fail & mon_en;
      mon_rst   = stopped & mon_hit & ~sc_en;
      sc_hit    = stopped & mon_hit & sc_en;
      sc_wake   = stopped & sc_ie & (sc_hit | sc_flag);
      wake      = stopped & ~mon_rst & (sc_wake | wake_irq);
      stop_exit = mon_rst | wake;
      wr_allow  = (state == ST_RUN) | stopped;

      state_d = state;
      unique case (state)
         ST_HOLD:     state_d = ST_SEQ_GO;
         ST_SEQ_GO:   state_d = ST_SEQ_WAIT;
         ST_SEQ_WAIT: if (rseq_done) state_d = ST_RUN;
         ST_RUN:      if (stop_req)  state_d = ST_STOP;
         ST_STOP: begin
            if (mon_rst)   state_d = ST_SEQ_GO;
            else if (wake) state_d = ST_RUN;
         end
         default:     state_d = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_HOLD;
         sc_flag   <= 1'b0;
         sc_active <= 1'b0;
         cq_start  <= 1'b0;
      end else begin
         state    <= state_d;
         cq_start <= wake & sc_wake;

         if (mon_rst)       sc_flag <= 1'b0;
         else if (sc_hit)   sc_flag <= 1'b1;
         else if (flag_clr) sc_flag <= 1'b0;

         if (mon_rst)              sc_active <= 1'b0;
         else if (wake & sc_wake)  sc_active <= 1'b1;
         else if (cq_done)         sc_active <= 1'b0;
      end
   end
endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
   import swk_pkg::*;
#(
   parameter int unsigned         SYNC_STAGES = 2,
   parameter logic [CFG_BITS-1:0] CFG_DEFAULT = 4'b0011
) (
   input  logic       clk,
   input  logic       ext_rst_req,
   input  logic       wdog_rst_req,
   input  logic       stop_req,
   input  logic       mon_fail,
   input  logic       wake_irq,
   input  logic       cfg_wr,
   input  logic [3:0] cfg_wdata,
   input  logic       flag_clr,
   input  logic       rseq_done,
   input  logic       cq_done,
   output logic       rseq_start,
   output logic [1:0] rst_cause,
   output logic       sc_irq,
   output logic       sc_flag,
   output logic       sc_active,
   output logic       cq_start,
   output logic       in_run,
   output logic       in_stop,
   output logic       pll_sel
);
   localparam int unsigned N_SRC = 2;

   if (CFG_BITS != 4) begin : g_bad_cfg
      $error("stopwake_ctrl: configuration layout must be 4 bits");
   end

   logic [N_SRC-1:0] src_req, src_rst_n;
   logic             sys_rst_n, ext_n, wdog_n;
   swk_state_e       state;
   swk_cfg_t         cfg_q;
   logic             mon_rst, stop_exit, wr_allow;
   logic [1:0]       cause_q;

   assign src_req = {wdog_rst_req, ext_rst_req};

   for (genvar i = 0; i < N_SRC; i++) begin : g_sync
      swk_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .req   (src_req[i]),
         .rst_n (src_rst_n[i])
      );
   end

   assign ext_n     = src_rst_n[0];
   assign wdog_n    = src_rst_n[1];
   assign sys_rst_n = ext_n & wdog_n;

   swk_cfg_regs #(.DEFAULT(CFG_DEFAULT)) u_cfg (
      .clk     (clk),
      .rst_n   (sys_rst_n),
      .wr_en   (cfg_wr & wr_allow),
      .wdata   (cfg_wdata),
      .restore (mon_rst),
      .pll_clr (stop_exit),
      .cfg     (cfg_q)
   );

   swk_fsm u_fsm (
      .clk       (clk),
      .rst_n     (sys_rst_n),
      .stop_req  (stop_req),
      .mon_fail  (mon_fail),
      .wake_irq  (wake_irq),
      .flag_clr  (flag_clr),
      .rseq_done (rseq_done),
      .cq_done   (cq_done),
      .mon_en    (cfg_q.mon_en),
      .sc_en     (cfg_q.sc_en),
      .sc_ie     (cfg_q.sc_ie),
      .state     (state),
      .sc_flag   (sc_flag),
      .sc_active (sc_active),
      .cq_start  (cq_start),
      .mon_rst   (mon_rst),
      .stop_exit (stop_exit),
      .wr_allow  (wr_allow)
   );

   // Cause register: external reset has priority over watchdog.
   always_ff @(posedge clk or negedge ext_n) begin
      if (!ext_n)       cause_q <= CAUSE_EXT;
      else if (!wdog_n) cause_q <= CAUSE_WDOG;
      else if (mon_rst) cause_q <= CAUSE_MON;
   end

   assign rst_cause  = cause_q;
   assign rseq_start = (state == ST_SEQ_GO);
   assign in_run     = (state == ST_RUN);
   assign in_stop    = (state == ST_STOP);
   assign sc_irq     = sc_flag & cfg_q.sc_ie;
   assign pll_sel    = cfg_q.pll_sel;
endmodule

module swk_chk
   import swk_pkg::*;
(
   input logic     clk,
   input logic     sys_rst_n,
   input logic     in_stop,
   input logic     in_run,
   input logic     rseq_start,
   input logic     cq_start,
   input logic     pll_sel,
   input logic     mon_fail,
   input logic     wake_irq,
   input logic     sc_flag,
   input swk_cfg_t cfg
);
   a_r1_rseq_single: assert property (@(posedge clk) disable iff (!sys_rst_n)
      rseq_start |=> !rseq_start);

   a_r3_exclusive: assert property (@(posedge clk) disable iff (!sys_rst_n)
      $onehot0({in_stop, in_run, rseq_start}));

   a_r4_mon_ignored: assert property (@(posedge clk) disable iff (!sys_rst_n)
      in_stop && mon_fail && !cfg.mon_en && !wake_irq && !(sc_flag && cfg.sc_ie)
      |=> in_stop);

   a_r6_cq_single: assert property (@(posedge clk) disable iff (!sys_rst_n)
      cq_start |=> !cq_start);

   a_r7_masked_stays: assert property (@(posedge clk) disable iff (!sys_rst_n)
      in_stop && mon_fail && cfg.mon_en && cfg.sc_en && !cfg.sc_ie && !wake_irq
      |=> in_stop && sc_flag);

   a_r9_wake: assert property (@(posedge clk) disable iff (!sys_rst_n)
      in_stop && wake_irq && !(mon_fail && cfg.mon_en && !cfg.sc_en) |=> in_run);

   a_r10_pll_clear_on_exit: assert property (@(posedge clk) disable iff (!sys_rst_n)
      $past(in_stop) && !in_stop |-> !pll_sel);
endmodule

bind stopwake_ctrl swk_chk u_chk (
   .clk        (clk),
   .sys_rst_n  (sys_rst_n),
   .in_stop    (in_stop),
   .in_run     (in_run),
   .rseq_start (rseq_start),
   .cq_start   (cq_start),
   .pll_sel    (pll_sel),
   .mon_fail   (mon_fail),
   .wake_irq   (wake_irq),
   .sc_flag    (sc_flag),
   .cfg        (cfg_q)
);

// File: tb/tb_stopwake_ctrl.sv
`timescale 1ns/1ps
module tb_stopwake_ctrl;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic ext_rst_req = 0, wdog_rst_req = 0, stop_req = 0, mon_fail = 0, wake_irq = 0;
   logic cfg_wr = 0, flag_clr = 0, rseq_done = 0, cq_done = 0;
   logic [3:0] cfg_wdata = 4'd0;
   logic rseq_start, sc_irq, sc_flag, sc_active, cq_start, in_run, in_stop, pll_sel;
   logic [1:0] rst_cause;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   stopwake_ctrl dut (
      .clk(clk), .ext_rst_req(ext_rst_req), .wdog_rst_req(wdog_rst_req),
      .stop_req(stop_req), .mon_fail(mon_fail), .wake_irq(wake_irq),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .flag_clr(flag_clr),
      .rseq_done(rseq_done), .cq_done(cq_done), .rseq_start(rseq_start),
      .rst_cause(rst_cause), .sc_irq(sc_irq), .sc_flag(sc_flag),
      .sc_active(sc_active), .cq_start(cq_start), .in_run(in_run),
      .in_stop(in_stop), .pll_sel(pll_sel)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic nclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Finish the reset sequence: wait for the start strobe, then acknowledge.
   task automatic finish_seq(input int exp_cause, input string tag);
      int k = 0;
      while (!rseq_start && k < 20) begin nclk(1); k++; end
      chk({tag, " rseq_start seen"}, rseq_start, 1);
      chk({tag, " cause"}, rst_cause, exp_cause);
      nclk(1);
      chk("R1 rseq_start single pulse", rseq_start, 0);
      rseq_done = 1;
      k = 0;
      while (!in_run && k < 20) begin nclk(1); k++; end
      rseq_done = 0;
      chk({tag, " run after done"}, in_run, 1);
   endtask

   task automatic do_reset(input bit e, input bit w, input int exp_cause, input string tag);
      nclk(1);
      ext_rst_req = e; wdog_rst_req = w;
      nclk(3);
      ext_rst_req = 0; wdog_rst_req = 0;
      finish_seq(exp_cause, tag);
   endtask

   task automatic wr_cfg(input logic [3:0] v);
      cfg_wr = 1; cfg_wdata = v;
      nclk(1);
      cfg_wr = 0;
   endtask

   task automatic go_stop();
      stop_req = 1;
      nclk(1);
      stop_req = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1/R2 reset state and causes
      do_reset(1, 0, 1, "R1 R2 ext");
      chk("R1 default pll_sel", pll_sel, 0);
      chk("R1 default no flag", sc_flag, 0);
      do_reset(0, 1, 2, "R2 wdog");
      do_reset(1, 1, 1, "R2 ext over wdog");

      // R1 default config: monitor enabled, self-clock enabled, irq masked
      go_stop();
      mon_fail = 1; nclk(1); mon_fail = 0;
      chk("R1 default cfg masked flag", sc_flag, 1);
      chk("R1 default cfg stays stop", in_stop, 1);

      // R1 async restore during stop
      do_reset(1, 0, 1, "R1 clear");
      wr_cfg(4'b1000);
      chk("R10 sw sets pll", pll_sel, 1);
      go_stop();
      ext_rst_req = 1; #1;
      chk("R1 async pll clear", pll_sel, 0);
      chk("R1 async leave stop", in_stop, 0);
      nclk(3); ext_rst_req = 0;
      finish_seq(1, "R1 ext in stop");

      // R3/R13: stop_req and cfg_wr ignored during reset sequence
      nclk(1);
      ext_rst_req = 1; nclk(3); ext_rst_req = 0;
      begin
         int k = 0;
         while (!rseq_start && k < 20) begin nclk(1); k++; end
      end
      nclk(1);
      stop_req = 1; cfg_wr = 1; cfg_wdata = 4'b1000;
      nclk(1);
      stop_req = 0; cfg_wr = 0;
      chk("R13 write ignored in sequence", pll_sel, 0);
      rseq_done = 1; nclk(1); nclk(1); rseq_done = 0;
      chk("R3 stop_req ignored outside run", in_stop, 0);
      chk("R3 run after done", in_run, 1);

      // R4..R11 sweep: config (mon_en, sc_en, sc_ie) x (failure, wake)
      for (int c = 0; c < 32; c++) begin
         bit m = c[0], s = c[1], i = c[2], f = c[3], w = c[4];
         bit mres = f & m & ~s;
         bit scw  = f & m & s & i;
         bit flg  = f & m & s;
         bit wk   = ~mres & (scw | w);
         string tg = (f && w) ? "R11" : (!m ? "R4" : (mres ? "R5" : (scw ? "R6" : (flg ? "R7" : "R9"))));
         do_reset(1, 0, 1, "R1 sweep");
         wr_cfg({1'b1, i, s, m});
         chk("R10 pll set", pll_sel, 1);
         go_stop();
         chk("R3 enter stop", in_stop, 1);
         mon_fail = f; wake_irq = w;
         nclk(1);
         mon_fail = 0; wake_irq = 0;
         chk({tg, " in_stop"}, in_stop, (!mres && !wk) ? 1 : 0);
         chk({tg, " in_run"}, in_run, wk ? 1 : 0);
         chk({tg, " rseq_start"}, rseq_start, mres ? 1 : 0);
         chk({tg, " R10 pll"}, pll_sel, (mres || wk) ? 0 : 1);
         chk({tg, " sc_flag"}, sc_flag, flg ? 1 : 0);
         chk({tg, " sc_irq"}, sc_irq, scw ? 1 : 0);
         chk({tg, " cq_start"}, cq_start, scw ? 1 : 0);
         chk({tg, " sc_active"}, sc_active, scw ? 1 : 0);
         if (mres) begin
            chk("R5 cause", rst_cause, 3);
            finish_seq(3, "R5 mon reset");
            chk("R5 cfg restored pll", pll_sel, 0);
         end else begin
            nclk(1);
            chk("R6 cq_start single", cq_start, 0);
            if (scw) begin
               cq_done = 1; nclk(1); cq_done = 0;
               chk("R12 sc_active drop", sc_active, 0);
               wr_cfg(4'b1000);
               chk("R10 sw sets pll again", pll_sel, 1);
            end
            if (flg && !wk) begin
               flag_clr = 1; nclk(1); flag_clr = 0;
               chk("R8 flag cleared", sc_flag, 0);
               chk("R8 still stop", in_stop, 1);
            end
         end
      end

      // R8 pending flag unmasked in stop
      do_reset(1, 0, 1, "R8 prep");
      wr_cfg(4'b1011);
      go_stop();
      mon_fail = 1; nclk(1); mon_fail = 0;
      chk("R7 flag set", sc_flag, 1);
      chk("R7 no irq", sc_irq, 0);
      nclk(2);
      chk("R8 flag sticky", sc_flag, 1);
      cfg_wr = 1; cfg_wdata = 4'b1111;
      nclk(1);
      cfg_wr = 0;
      chk("R8 irq raised", sc_irq, 1);
      chk("R8 still stop one cycle", in_stop, 1);
      nclk(1);
      chk("R8 woke", in_run, 1);
      chk("R8 cq_start", cq_start, 1);
      chk("R8 sc_active", sc_active, 1);
      chk("R10 pll cleared", pll_sel, 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule